// File: doc/BRIEF.md
# Strobe-Latched Probe Register Bank

This block lets host software watch and steer signals deep inside a design through a plain synchronous register port. Four input probes are driven by the surrounding logic and read by the host. Four output probes are written by the host and drive the surrounding logic. Each probe sits behind a shadow buffer. A buffer wider than the 16-bit bus word is split over consecutive addresses, with the least significant word at the lowest address.

Nothing moves between a probe and its buffer until the host toggles a single control bit. A rising transition of that bit does two things in one clock. It snapshots every input probe into its buffer, and it copies every output buffer onto its live output. The host can therefore stage several outputs of any width, or sample several inputs, and know they change or were taken together. Each output has its own reset value, set by a parameter.

With the default parameters the address map is as follows:

| Address | Contents |
|---|---|
| 0 | control bit (bit 0) |
| 1–5 | input buffers (widths 1, 2, 8, 20) |
| 6–10 | output buffers (widths 1, 2, 8, 20) |

Top module: `probe_regbank`

## Requirements
- R1: After reset, the control register (address 0) and every input buffer word (addresses 1 to 5) read as zero.
- R2: After reset, the outputs `out_p0`..`out_p3` and their buffers hold 1, 2, 0 and 0x10002. The buffer words at addresses 6, 7, 8, 9 and 10 read 0x0001, 0x0002, 0x0000, 0x0002 and 0x0001.
- R3: Address 0 holds the control bit in bit 0. The input buffers for widths 1, 2, 8 and 20 are at 1, 2, 3 and 4–5. The output buffers for the same widths are at 6, 7, 8 and 9–10. A 20-bit buffer keeps bits 15:0 at its lower address and bits 19:16 at the next address.
- R4: A host read of an output buffer word returns the value most recently written there, masked to the probe width.
- R5: Writing an output buffer leaves the live output unchanged until the next transfer.
- R6: A transfer happens when the stored control bit goes from 0 to 1. Counting from the clock edge that stores the 1, the outputs take the buffer values at the following clock edge.
- R7: The same transfer edge captures the present value of every input probe into its buffer. The host then reads that value from the buffer addresses.
- R8: Keeping the control bit at 1, or clearing it to 0, causes no further transfer.
- R9: Writes to input buffer addresses are ignored.
- R10: A read of an address with nothing mapped returns zero.
- R11: Bits above a probe's width in its top word read as zero, and writes to them are discarded.
- R12: Read data appears on `bus_rdata` one cycle after a request. In a cycle after one with no read request, `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write request |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read request |
| bus_rdata | output | 16 | Registered read data |
| in_p0 | input | 1 | Input probe 0 |
| in_p1 | input | 2 | Input probe 1 |
| in_p2 | input | 8 | Input probe 2 |
| in_p3 | input | 20 | Input probe 3 |
| out_p0 | output | 1 | Output probe 0 |
| out_p1 | output | 2 | Output probe 1 |
| out_p2 | output | 8 | Output probe 2 |
| out_p3 | output | 20 | Output probe 3 |

## Verification
The bench first targets the control bit.

- Holding the bit high while the inputs and buffers change must not move anything. A level-sensitive design would keep copying.
- Writing a buffer and raising the bit in the same stretch checks that an output changes only one edge after the bit is stored. A design that wired buffers straight to outputs would show every write at once.

It then targets the address map.

- Writing all ones to the upper word of the 20-bit output exposes bits above the width. A design that kept them would read back 0xFFFF instead of 0x000F.
- Writing to input addresses and to unmapped addresses checks that neither alters a buffer or returns anything but zero.

Random traffic then runs against a behavioural model compared on every clock.

// File: rtl/probe_regbank_pkg.sv
package probe_regbank_pkg;

   // number of bus words needed to hold a probe of width w
   function automatic int words_for(int w, int dw);
      return (w + dw - 1) / dw;
   endfunction

endpackage

// File: rtl/probe_word_view.sv
// Presents one word of a probe buffer to the read path.
module probe_word_view
   import probe_regbank_pkg::*;
#(
   parameter int W    = 8,
   parameter int DW   = 16,
   parameter int AW   = 8,
   parameter int BASE = 1
) (
   input  logic [AW-1:0] addr,
   input  logic [W-1:0]  value,
   output logic [DW-1:0] rd_word
);
   localparam int NW = words_for(W, DW);
   localparam int PW = NW * DW;

   logic [PW-1:0] pad;
   logic [AW-1:0] off;
   logic          hit;

   assign pad = PW'(value);
   assign off = addr - AW'(BASE);
   assign hit = (addr >= AW'(BASE)) && (addr < AW'(BASE + NW));
   // bits above W are zero in pad, so the top word reads zero there (R11)
   assign rd_word = hit ? DW'(pad >> (int'(off) * DW)) : '0;
endmodule

// File: rtl/probe_in_slot.sv
// Read-only buffer that snapshots an input probe on a transfer.
module probe_in_slot #(
   parameter int W    = 8,
   parameter int DW   = 16,
   parameter int AW   = 8,
   parameter int BASE = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          xfer,
   input  logic [AW-1:0] addr,
   input  logic [W-1:0]  probe_in,
   output logic [DW-1:0] rd_word
);
   logic [W-1:0] buf_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    buf_q <= '0;
      else if (xfer) buf_q <= probe_in;
   end

   probe_word_view #(.W(W), .DW(DW), .AW(AW), .BASE(BASE)) u_view (
      .addr(addr), .value(buf_q), .rd_word(rd_word)
   );

   a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |=> buf_q == $past(probe_in));
   // host writes never reach this buffer (R9)
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer |=> $stable(buf_q));
endmodule

// File: rtl/probe_out_slot.sv
// Host-writable buffer plus the live output it feeds on a transfer.
module probe_out_slot
   import probe_regbank_pkg::*;
#(
   parameter int          W    = 8,
   parameter int          DW   = 16,
   parameter int          AW   = 8,
   parameter int          BASE = 6,
   parameter logic [63:0] INIT = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          xfer,
   input  logic [AW-1:0] addr,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   output logic [W-1:0]  live,
   output logic [DW-1:0] rd_word
);
   localparam int NW = words_for(W, DW);
   localparam int PW = NW * DW;

   logic [W-1:0]  buf_q, live_q;
   logic [AW-1:0] off;
   logic          whit;
   logic [PW-1:0] wmask, wval, merged;

   assign off    = addr - AW'(BASE);
   assign whit   = wr && (addr >= AW'(BASE)) && (addr < AW'(BASE + NW));
   assign wmask  = PW'({DW{1'b1}}) << (int'(off) * DW);
   assign wval   = PW'(wdata) << (int'(off) * DW);
   assign merged = (PW'(buf_q) & ~wmask) | (wval & wmask);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_q  <= INIT[W-1:0];
         live_q <= INIT[W-1:0];
      end else begin
         if (whit) buf_q  <= merged[W-1:0];  // upper pad bits dropped (R11)
         if (xfer) live_q <= buf_q;
      end
   end

   assign live = live_q;

   probe_word_view #(.W(W), .DW(DW), .AW(AW), .BASE(BASE)) u_view (
      .addr(addr), .value(buf_q), .rd_word(rd_word)
   );

   a_r5_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer |=> $stable(live_q));
   a_r6_live_load: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |=> live_q == $past(buf_q));
endmodule

// File: rtl/probe_strobe.sv
// Control bit and its rising-edge transfer pulse.
module probe_strobe #(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [AW-1:0] addr,
   input  logic          wbit,
   output logic          level,
   output logic          xfer
);
   logic bit_q, prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_q  <= 1'b0;
         prev_q <= 1'b0;
      end else begin
         if (wr && addr == '0) bit_q <= wbit;
         prev_q <= bit_q;
      end
   end

   assign level = bit_q;
   assign xfer  = bit_q & ~prev_q;

   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |=> !xfer);
endmodule

// File: rtl/probe_regbank.sv
module probe_regbank
   import probe_regbank_pkg::*;
#(
   parameter int          DW        = 16,
   parameter int          AW        = 8,
   parameter int          W_IN0     = 1,
   parameter int          W_IN1     = 2,
   parameter int          W_IN2     = 8,
   parameter int          W_IN3     = 20,
   parameter int          W_OUT0    = 1,
   parameter int          W_OUT1    = 2,
   parameter int          W_OUT2    = 8,
   parameter int          W_OUT3    = 20,
   parameter logic [63:0] INIT_OUT0 = 64'd1,
   parameter logic [63:0] INIT_OUT1 = 64'd2,
   parameter logic [63:0] INIT_OUT2 = 64'd0,
   parameter logic [63:0] INIT_OUT3 = 64'd65538
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     bus_addr,
   input  logic              bus_wr,
   input  logic [DW-1:0]     bus_wdata,
   input  logic              bus_rd,
   output logic [DW-1:0]     bus_rdata,
   input  logic [W_IN0-1:0]  in_p0,
   input  logic [W_IN1-1:0]  in_p1,
   input  logic [W_IN2-1:0]  in_p2,
   input  logic [W_IN3-1:0]  in_p3,
   output logic [W_OUT0-1:0] out_p0,
   output logic [W_OUT1-1:0] out_p1,
   output logic [W_OUT2-1:0] out_p2,
   output logic [W_OUT3-1:0] out_p3
);
   localparam int NP = 4;
   localparam int IN_W  [NP] = '{W_IN0, W_IN1, W_IN2, W_IN3};
   localparam int OUT_W [NP] = '{W_OUT0, W_OUT1, W_OUT2, W_OUT3};
   localparam logic [63:0] OUT_INIT [NP] = '{INIT_OUT0, INIT_OUT1, INIT_OUT2, INIT_OUT3};
   localparam int IN_NW  [NP] = '{words_for(W_IN0, DW), words_for(W_IN1, DW),
                                  words_for(W_IN2, DW), words_for(W_IN3, DW)};
   localparam int OUT_NW [NP] = '{words_for(W_OUT0, DW), words_for(W_OUT1, DW),
                                  words_for(W_OUT2, DW), words_for(W_OUT3, DW)};
   localparam int IN_LSB  [NP] = '{0, W_IN0, W_IN0 + W_IN1, W_IN0 + W_IN1 + W_IN2};
   localparam int OUT_LSB [NP] = '{0, W_OUT0, W_OUT0 + W_OUT1, W_OUT0 + W_OUT1 + W_OUT2};
   localparam int IN_TOT  = W_IN0 + W_IN1 + W_IN2 + W_IN3;
   localparam int OUT_TOT = W_OUT0 + W_OUT1 + W_OUT2 + W_OUT3;
   // control bit at 0, then inputs, then outputs, each word-aligned
   localparam int IN_BASE [NP] = '{1, 1 + IN_NW[0], 1 + IN_NW[0] + IN_NW[1],
                                   1 + IN_NW[0] + IN_NW[1] + IN_NW[2]};
   localparam int OUT_BASE0 = IN_BASE[3] + IN_NW[3];
   localparam int OUT_BASE [NP] = '{OUT_BASE0, OUT_BASE0 + OUT_NW[0],
                                    OUT_BASE0 + OUT_NW[0] + OUT_NW[1],
                                    OUT_BASE0 + OUT_NW[0] + OUT_NW[1] + OUT_NW[2]};
   localparam int LAST_ADDR = OUT_BASE[3] + OUT_NW[3] - 1;

   if (DW < 2 || DW > 64) begin : g_bad_dw
      $error("DW out of range");
   end
   if (LAST_ADDR >= (1 << AW)) begin : g_bad_aw
      $error("address map does not fit AW");
   end
   for (genvar c = 0; c < NP; c++) begin : g_chk
      if (IN_W[c] < 1 || IN_W[c] > 64 || OUT_W[c] < 1 || OUT_W[c] > 64) begin : g_bad_w
         $error("probe width out of range");
      end
   end

   logic                 strobe_lvl, xfer;
   logic [IN_TOT-1:0]    in_flat;
   logic [OUT_TOT-1:0]   out_flat;
   logic [DW-1:0]        in_rd  [NP];
   logic [DW-1:0]        out_rd [NP];
   logic [DW-1:0]        rd_next;

   assign in_flat = {in_p3, in_p2, in_p1, in_p0};

   probe_strobe #(.AW(AW)) u_strobe (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
      .wbit(bus_wdata[0]), .level(strobe_lvl), .xfer(xfer)
   );

   for (genvar g = 0; g < NP; g++) begin : g_probe
      probe_in_slot #(.W(IN_W[g]), .DW(DW), .AW(AW), .BASE(IN_BASE[g])) u_in (
         .clk(clk), .rst_n(rst_n), .xfer(xfer), .addr(bus_addr),
         .probe_in(in_flat[IN_LSB[g] +: IN_W[g]]), .rd_word(in_rd[g])
      );
      probe_out_slot #(.W(OUT_W[g]), .DW(DW), .AW(AW), .BASE(OUT_BASE[g]),
                       .INIT(OUT_INIT[g])) u_out (
         .clk(clk), .rst_n(rst_n), .xfer(xfer), .addr(bus_addr),
         .wr(bus_wr), .wdata(bus_wdata),
         .live(out_flat[OUT_LSB[g] +: OUT_W[g]]), .rd_word(out_rd[g])
      );
   end

   assign out_p0 = out_flat[OUT_LSB[0] +: W_OUT0];
   assign out_p1 = out_flat[OUT_LSB[1] +: W_OUT1];
   assign out_p2 = out_flat[OUT_LSB[2] +: W_OUT2];
   assign out_p3 = out_flat[OUT_LSB[3] +: W_OUT3];

   // every word view returns zero when not addressed, so OR is the mux
   always_comb begin
      rd_next = (bus_addr == '0) ? DW'(strobe_lvl) : '0;
      for (int k = 0; k < NP; k++) rd_next |= in_rd[k] | out_rd[k];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_next;
      else             bus_rdata <= '0;
   end

   a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> bus_rdata == '0);
   a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && int'(bus_addr) > LAST_ADDR) |=> bus_rdata == '0);
endmodule

// File: tb/test_probe_regbank.sv
module test_probe_regbank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [0:0]  in_p0 = '0;
   logic [1:0]  in_p1 = '0;
   logic [7:0]  in_p2 = '0;
   logic [19:0] in_p3 = '0;
   logic [0:0]  out_p0;
   logic [1:0]  out_p1;
   logic [7:0]  out_p2;
   logic [19:0] out_p3;

   int checks = 0, errors = 0;
   bit model_on = 1'b0;

   always #5 clk = ~clk;

   probe_regbank i_probe_regbank (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .in_p0(in_p0), .in_p1(in_p1), .in_p2(in_p2), .in_p3(in_p3),
      .out_p0(out_p0), .out_p1(out_p1), .out_p2(out_p2), .out_p3(out_p3)
   );

   // ---------------- behavioural reference ----------------
   int BW [4] = '{1, 2, 8, 20};
   int IB [4] = '{1, 2, 3, 4};
   int OB [4] = '{6, 7, 8, 9};
   int NW [4] = '{1, 1, 1, 2};
   logic [31:0] m_ib [4];
   logic [31:0] m_ob [4];
   logic [31:0] m_ol [4];
   logic        m_st, m_pv;
   logic [15:0] m_rd;

   function automatic logic [31:0] wmask(int w);
      return (32'd1 << w) - 32'd1;
   endfunction

   function automatic logic [31:0] in_val(int k);
      case (k)
         0: return 32'(in_p0);
         1: return 32'(in_p1);
         2: return 32'(in_p2);
         default: return 32'(in_p3);
      endcase
   endfunction

   function automatic logic [31:0] out_val(int k);
      case (k)
         0: return 32'(out_p0);
         1: return 32'(out_p1);
         2: return 32'(out_p2);
         default: return 32'(out_p3);
      endcase
   endfunction

   function automatic logic [15:0] model_read(int a);
      if (a == 0) return {15'd0, m_st};
      for (int k = 0; k < 4; k++) begin
         if (a >= IB[k] && a < IB[k] + NW[k]) return 16'(m_ib[k] >> (16 * (a - IB[k])));
         if (a >= OB[k] && a < OB[k] + NW[k]) return 16'(m_ob[k] >> (16 * (a - OB[k])));
      end
      return 16'd0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st <= 1'b0; m_pv <= 1'b0; m_rd <= '0;
         m_ob[0] <= 32'd1; m_ob[1] <= 32'd2; m_ob[2] <= 32'd0; m_ob[3] <= 32'd65538;
         m_ol[0] <= 32'd1; m_ol[1] <= 32'd2; m_ol[2] <= 32'd0; m_ol[3] <= 32'd65538;
         for (int k = 0; k < 4; k++) m_ib[k] <= '0;
      end else begin
         m_rd <= bus_rd ? model_read(int'(bus_addr)) : 16'd0;
         if (bus_wr && bus_addr == 8'd0) m_st <= bus_wdata[0];
         m_pv <= m_st;
         for (int k = 0; k < 4; k++) begin
            if (bus_wr && int'(bus_addr) >= OB[k] && int'(bus_addr) < OB[k] + NW[k]) begin
               int sh;
               sh = 16 * (int'(bus_addr) - OB[k]);
               m_ob[k] <= ((m_ob[k] & ~(32'hFFFF << sh)) | (32'(bus_wdata) << sh)) & wmask(BW[k]);
            end
            if (m_st && !m_pv) begin
               m_ol[k] <= m_ob[k];
               m_ib[k] <= in_val(k) & wmask(BW[k]);
            end
         end
      end
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // model comparison on every clock, away from the active edge
   always @(negedge clk) begin
      if (model_on) begin
         check("R12 rdata vs model", 32'(bus_rdata), 32'(m_rd));
         for (int k = 0; k < 4; k++) check("R6 live vs model", out_val(k), m_ol[k]);
      end
   end

   // ---------------- bus tasks ----------------
   task automatic wr(int a, logic [15:0] d);
      @(negedge clk);
      bus_addr = 8'(a); bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_check(int a, logic [15:0] exp, string req);
      @(negedge clk);
      bus_addr = 8'(a); bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      check(req, 32'(bus_rdata), 32'(exp));
   endtask

   task automatic pulse();
      wr(0, 16'd0);
      wr(0, 16'd1);
      wr(0, 16'd0);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model_on = 1'b1;
      @(negedge clk);

      // R1 / R2 reset values
      check("R2 out_p0 reset", 32'(out_p0), 32'd1);
      check("R2 out_p1 reset", 32'(out_p1), 32'd2);
      check("R2 out_p2 reset", 32'(out_p2), 32'd0);
      check("R2 out_p3 reset", 32'(out_p3), 32'd65538);
      rd_check(0, 16'd0, "R1 control reads 0");
      for (int a = 1; a <= 5; a++) rd_check(a, 16'd0, "R1 input buffer zero");
      rd_check(6, 16'h0001, "R2 out buf0");
      rd_check(7, 16'h0002, "R2 out buf1");
      rd_check(8, 16'h0000, "R2 out buf2");
      rd_check(9, 16'h0002, "R3 R2 out buf3 low word");
      rd_check(10, 16'h0001, "R3 R2 out buf3 high word");

      // R4 / R11 / R5 writes to output buffers
      wr(6, 16'hFFFE);
      wr(7, 16'h0003);
      wr(8, 16'h12A5);
      wr(9, 16'hBEEF);
      wr(10, 16'hFFFF);
      rd_check(6, 16'h0000, "R11 out buf0 masked");
      rd_check(7, 16'h0003, "R4 out buf1 readback");
      rd_check(8, 16'h00A5, "R11 out buf2 masked");
      rd_check(9, 16'hBEEF, "R4 out buf3 low");
      rd_check(10, 16'h000F, "R11 out buf3 high masked");
      check("R5 out_p1 unchanged", 32'(out_p1), 32'd2);
      check("R5 out_p3 unchanged", 32'(out_p3), 32'd65538);

      // R9 writes to input buffers ignored
      wr(3, 16'h1234);
      wr(5, 16'hFFFF);
      rd_check(3, 16'd0, "R9 input write ignored");
      rd_check(5, 16'd0, "R9 input write ignored");

      // R6 / R7 transfer: outputs change one edge after the 1 is stored
      in_p0 = 1'b1; in_p1 = 2'b10; in_p2 = 8'h3C; in_p3 = 20'hABCDE;
      wr(0, 16'd0);
      @(negedge clk);
      bus_addr = 8'd0; bus_wdata = 16'd1; bus_wr = 1'b1;
      @(negedge clk);  // 1 stored at the edge just passed
      bus_wr = 1'b0;
      check("R6 no change in storing cycle", 32'(out_p3), 32'd65538);
      @(negedge clk);
      check("R6 out_p0 loaded", 32'(out_p0), 32'd0);
      check("R6 out_p1 loaded", 32'(out_p1), 32'd3);
      check("R6 out_p2 loaded", 32'(out_p2), 32'hA5);
      check("R6 out_p3 loaded", 32'(out_p3), 32'hFBEEF);
      rd_check(0, 16'd1, "R3 control bit reads back");
      rd_check(1, 16'h0001, "R7 in0 captured");
      rd_check(2, 16'h0002, "R7 in1 captured");
      rd_check(3, 16'h003C, "R7 in2 captured");
      rd_check(4, 16'hBCDE, "R7 R3 in3 low word");
      rd_check(5, 16'h000A, "R7 R3 in3 high word");

      // R8 held level: no further transfer
      in_p2 = 8'h55;
      wr(8, 16'h0077);
      wr(0, 16'd1);
      repeat (3) @(negedge clk);
      rd_check(3, 16'h003C, "R8 no capture while held");
      check("R8 out_p2 held", 32'(out_p2), 32'hA5);
      wr(0, 16'd0);
      repeat (2) @(negedge clk);
      check("R8 falling edge no transfer", 32'(out_p2), 32'hA5);
      rd_check(3, 16'h003C, "R8 falling edge no capture");
      pulse();
      @(negedge clk);
      check("R6 second transfer", 32'(out_p2), 32'h77);
      rd_check(3, 16'h0055, "R7 second capture");

      // R10 unmapped, R12 idle
      rd_check(11, 16'd0, "R10 unmapped 11");
      rd_check(200, 16'd0, "R10 unmapped 200");
      @(negedge clk);
      check("R12 idle rdata zero", 32'(bus_rdata), 32'd0);

      // random traffic against the model
      for (int n = 0; n < 600; n++) begin
         @(negedge clk);
         bus_addr  = 8'($urandom_range(0, 12));
         bus_wdata = 16'($urandom);
         bus_wr    = ($urandom_range(0, 2) == 0);
         bus_rd    = ($urandom_range(0, 1) == 0);
         if (bus_addr == 8'd0) bus_wdata[0] = ($urandom_range(0, 1) == 1);
         in_p0 = 1'($urandom); in_p1 = 2'($urandom);
         in_p2 = 8'($urandom); in_p3 = 20'($urandom);
      end
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      repeat (3) @(negedge clk);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule